// File: doc/BRIEF.md
# Handshaked Serial Byte Transfer Port

This block moves one byte at a time between a host and a power-management microcontroller. The microcontroller supplies the shift clock. The host starts a transfer with a single-cycle command that selects the direction and, for a send, supplies the byte. The port then drives an active-low request line and shifts eight bits on the rising edges of the external clock. After the eighth edge it negates the request and waits for the peripheral to release its active-low acknowledge line. Only then does it report the byte as done.

If the acknowledge line is still asserted when the eighth bit lands, the port raises a warning flag. If the acknowledge line is not released within a programmable number of clock cycles, the port gives up with a one-cycle timeout pulse and returns to idle. Command framing, shift clock generation and the peripheral itself lie outside this block.

Top module: `hs_byte_port`

## Requirements
- R1: After reset, and whenever the port is idle, `req_no` is high (negated) and `busy_o`, `done_o`, `timeout_o` and `sdata_oe_o` are low.
- R2: A `start_i` pulse while idle is accepted. In the next cycle `busy_o` is 1 and `req_no` is 0 (asserted).
- R3: In a send (`dir_tx_i`=1), `sdata_oe_o` is 1 while bits are shifted. Before each rising edge of the synchronized `sclk_i`, `sdata_o` presents the next bit of `tx_byte_i`, MSB first.
- R4: In a receive (`dir_tx_i`=0), `sdata_i` is sampled on each of 8 rising `sclk_i` edges, MSB first. Old shifter contents are discarded at start. The assembled byte appears on `rx_byte_o` in the cycle `done_o` pulses, and it is held after that.
- R5: After the eighth rising `sclk_i` edge, `req_no` returns high before any completion is reported.
- R6: `done_o` is a one-cycle pulse. It is issued only once the synchronized `ack_ni` reads high after the byte completes.
- R7: `ack_warn_o` is set to 1 if `ack_ni` is still low (asserted) when the eighth bit completes, and to 0 otherwise. It holds that value until the next accepted start.
- R8: If `ack_ni` stays low after the byte completes, `timeout_o` pulses exactly ACK_WAIT_CYC cycles after `req_no` rises. `done_o` does not pulse, and the port returns to idle with `req_no` high.
- R9: `start_i` while `busy_o` is 1 is ignored. The byte in flight and its direction are unchanged, and no extra completion occurs.
- R10: `sclk_i` edges while idle have no effect. `busy_o` stays 0 and neither `done_o` nor `timeout_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one byte transfer (single-cycle pulse) |
| dir_tx_i | input | 1 | 1 = send `tx_byte_i`, 0 = receive |
| tx_byte_i | input | 8 | Byte to send, sampled with `start_i` |
| busy_o | output | 1 | Transfer in progress; new starts are ignored |
| done_o | output | 1 | One-cycle pulse: byte finished and acknowledge released |
| rx_byte_o | output | 8 | Last received byte |
| ack_warn_o | output | 1 | Acknowledge was still asserted at byte completion |
| timeout_o | output | 1 | One-cycle pulse: acknowledge not released in time |
| sclk_i | input | 1 | Shift clock from the peripheral |
| sdata_i | input | 1 | Serial data from the peripheral |
| sdata_o | output | 1 | Serial data to the peripheral |
| sdata_oe_o | output | 1 | Drive enable for `sdata_o` |
| req_no | output | 1 | Transfer request to the peripheral, active low |
| ack_ni | input | 1 | Acknowledge from the peripheral, active low |

## Verification
Some results have fixed latencies. Request assertion and busy follow an accepted start by exactly one cycle, and the timeout pulse comes exactly ACK_WAIT_CYC cycles after the request rises. The bench samples these at the falling edge of the cycle where they are due. A free-running counter in the monitor counts cycles spent waiting with the request high. Done depends on the two-flop synchronizers, so the monitor does not pin it to a fixed cycle. Instead, a driver task queues the expected item (completion or timeout, received byte, warning level), and the monitor pops and compares it whenever a pulse appears. The peripheral model samples transmitted bits just before each clock rise, which is at least six cycles after the shifter has settled.

// File: rtl/hsbp_pkg.sv
package hsbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2
  } hsbp_state_e;
endpackage

// File: rtl/hsbp_sync.sv
module hsbp_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/hsbp_shifter.sv
module hsbp_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] data_o,
  output logic         msb_o,
  output logic         last_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= clear_i ? '0 : load_val_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[W-2:0], din_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_o = sh_q;
  assign msb_o  = sh_q[W-1];
  // this shift completes the byte
  assign last_o = shift_i && (cnt_q == CW'(W - 1));
endmodule

// File: rtl/hsbp_ctrl.sv
module hsbp_ctrl
  import hsbp_pkg::*;
#(
  parameter int ACK_WAIT_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dir_tx_i,
  input  logic edge_i,
  input  logic last_i,
  input  logic ack_s_i,
  output logic load_o,
  output logic clear_o,
  output logic shift_o,
  output logic cap_o,
  output logic dir_tx_o,
  output logic shifting_o,
  output logic busy_o,
  output logic req_no,
  output logic done_o,
  output logic timeout_o,
  output logic warn_o
);
  localparam int TW = $clog2(ACK_WAIT_CYC + 1);

  hsbp_state_e st_q;
  logic [TW-1:0] wcnt_q;
  logic req_q, dir_q, done_q, to_q, warn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      req_q  <= 1'b1;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SHIFT;
          req_q  <= 1'b0;
          dir_q  <= dir_tx_i;
          warn_q <= 1'b0;
        end
        ST_SHIFT: if (last_i) begin
          st_q   <= ST_WAIT;
          req_q  <= 1'b1;
          warn_q <= ~ack_s_i;
          wcnt_q <= '0;
        end
        ST_WAIT: begin
          if (ack_s_i) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (wcnt_q == TW'(ACK_WAIT_CYC - 1)) begin
            to_q <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o     = (st_q == ST_IDLE) && start_i;
  assign clear_o    = ~dir_tx_i;
  assign shift_o    = (st_q == ST_SHIFT) && edge_i;
  assign cap_o      = (st_q == ST_WAIT) && ack_s_i && !dir_q;
  assign dir_tx_o   = dir_q;
  assign shifting_o = (st_q == ST_SHIFT);
  assign busy_o     = (st_q != ST_IDLE);
  assign req_no     = req_q;
  assign done_o     = done_q;
  assign timeout_o  = to_q;
  assign warn_o     = warn_q;
endmodule

// File: rtl/hs_byte_port.sv
module hs_byte_port #(
  parameter int DW           = 8,
  parameter int ACK_WAIT_CYC = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_tx_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          ack_warn_o,
  output logic          timeout_o,
  input  logic          sclk_i,
  input  logic          sdata_i,
  output logic          sdata_o,
  output logic          sdata_oe_o,
  output logic          req_no,
  input  logic          ack_ni
);
  logic [2:0] sync_s;
  logic sclk_s, sdata_s, ack_s, sclk_q, edge_w;
  logic load_w, clear_w, shift_w, cap_w, dir_q, shifting_w, last_w, msb_w;
  logic [DW-1:0] sh_w;

  // {ack, data, clk}; ack idles high
  hsbp_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ack_ni, sdata_i, sclk_i}),
    .q_o   (sync_s)
  );
  assign sclk_s  = sync_s[0];
  assign sdata_s = sync_s[1];
  assign ack_s   = sync_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end
  assign edge_w = sclk_s & ~sclk_q;

  hsbp_shifter #(.W(DW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_w),
    .clear_i   (clear_w),
    .load_val_i(tx_byte_i),
    .shift_i   (shift_w),
    .din_i     (sdata_s & ~dir_q),
    .data_o    (sh_w),
    .msb_o     (msb_w),
    .last_o    (last_w)
  );

  hsbp_ctrl #(.ACK_WAIT_CYC(ACK_WAIT_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .dir_tx_i  (dir_tx_i),
    .edge_i    (edge_w),
    .last_i    (last_w),
    .ack_s_i   (ack_s),
    .load_o    (load_w),
    .clear_o   (clear_w),
    .shift_o   (shift_w),
    .cap_o     (cap_w),
    .dir_tx_o  (dir_q),
    .shifting_o(shifting_w),
    .busy_o    (busy_o),
    .req_no    (req_no),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .warn_o    (ack_warn_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rx_byte_o <= '0;
    else if (cap_w) rx_byte_o <= sh_w;
  end

  assign sdata_oe_o = shifting_w & dir_q;
  assign sdata_o    = sdata_oe_o & msb_w;
endmodule

// File: rtl/hsbp_checker.sv
module hsbp_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic sdata_oe_o,
  input logic req_no
);
  p_idle_req_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> req_no);
  p_start_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !req_no));
  p_oe_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> (busy_o && !req_no));
  p_done_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_no && !busy_o));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  p_timeout_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (req_no && !busy_o));
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !req_no && start_i) |=> busy_o);
endmodule

bind hs_byte_port hsbp_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .timeout_o (timeout_o),
  .sdata_oe_o(sdata_oe_o),
  .req_no    (req_no)
);

// File: tb/tb_hs_byte_port.sv
module tb_hs_byte_port;
  localparam int LIMIT = 40;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, dir_tx_i = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic busy_o, done_o, ack_warn_o, timeout_o;
  logic [7:0] rx_byte_o;
  logic sclk_i = 1'b0, sdata_i = 1'b0, sdata_o, sdata_oe_o, req_no;
  logic ack_ni = 1'b1;

  int n_chk = 0, n_fail = 0;

  typedef struct { bit is_to; bit is_rx; logic [7:0] rx; bit warn; } exp_t;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  hs_byte_port #(.DW(8), .ACK_WAIT_CYC(LIMIT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dir_tx_i(dir_tx_i),
    .tx_byte_i(tx_byte_i), .busy_o(busy_o), .done_o(done_o), .rx_byte_o(rx_byte_o),
    .ack_warn_o(ack_warn_o), .timeout_o(timeout_o), .sclk_i(sclk_i),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .req_no(req_no), .ack_ni(ack_ni)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and wait-window timing
  int wait_cnt = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o || timeout_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected completion", {done_o, timeout_o}, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(timeout_o == e.is_to, "R8 completion kind", timeout_o, e.is_to);
          chk(done_o != e.is_to, "R6 done pulse", done_o, !e.is_to);
          chk(req_no == 1'b1, "R5 req high at completion", req_no, 1);
          if (!e.is_to) chk(ack_warn_o == e.warn, "R7 ack warn", ack_warn_o, e.warn);
          if (!e.is_to && e.is_rx) chk(rx_byte_o == e.rx, "R4 rx byte", rx_byte_o, e.rx);
          if (e.is_to) begin
            chk(wait_cnt == LIMIT, "R8 timeout latency", wait_cnt, LIMIT);
            chk(!busy_o, "R8 back to idle", busy_o, 0);
          end
        end
      end
      if (busy_o && req_no) wait_cnt++;
      else wait_cnt = 0;
    end
  end

  // ack_mode: 0 release with last edge, 1 release late, 2 never (timeout)
  task automatic xfer(input bit tx, input logic [7:0] val, input int ack_mode,
                      input bit inject);
    exp_t e;
    logic [7:0] got;
    e.is_to = (ack_mode == 2);
    e.is_rx = !tx;
    e.rx = val;
    e.warn = (ack_mode == 1);
    q.push_back(e);
    @(negedge clk_i);
    start_i = 1'b1; dir_tx_i = tx; tx_byte_i = tx ? val : 8'h00;
    @(negedge clk_i);
    start_i = 1'b0; tx_byte_i = ~val; dir_tx_i = ~tx;
    chk(busy_o && !req_no, "R2 start accepted", {busy_o, req_no}, 2'b10);
    ack_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      sdata_i = val[7-i];
      if (inject && i == 3) begin
        start_i = 1'b1; dir_tx_i = ~tx; tx_byte_i = 8'h00;
        @(negedge clk_i);
        start_i = 1'b0;
        chk(busy_o, "R9 busy kept", busy_o, 1);
        repeat (5) @(negedge clk_i);
      end else begin
        repeat (6) @(negedge clk_i);
      end
      if (tx) begin
        got[7-i] = sdata_o;
        if (i == 0) chk(sdata_oe_o, "R3 data enable", sdata_oe_o, 1);
      end else if (i == 0) begin
        chk(!sdata_oe_o, "R4 no drive in receive", sdata_oe_o, 0);
      end
      sclk_i = 1'b1;
      if (i == 7 && ack_mode == 0) ack_ni = 1'b1;
      repeat (6) @(negedge clk_i);
      sclk_i = 1'b0;
    end
    if (tx) chk(got == val, "R3 tx bits MSB first", got, val);
    if (ack_mode == 1) begin
      repeat (4) @(negedge clk_i);
      ack_ni = 1'b1;
    end
    while (busy_o) @(negedge clk_i);
    ack_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(q.size() == 0, "R6 completion seen", q.size(), 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_no && !busy_o && !done_o && !timeout_o && !sdata_oe_o,
        "R1 reset state", {req_no, busy_o, done_o, timeout_o, sdata_oe_o}, 5'b10000);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(req_no && !busy_o, "R1 idle", {req_no, busy_o}, 2'b10);

    xfer(1'b1, 8'hA5, 0, 1'b0);
    xfer(1'b0, 8'h3C, 0, 1'b0);
    xfer(1'b1, 8'h80, 1, 1'b0);
    xfer(1'b0, 8'hC1, 2, 1'b0);
    chk(req_no && !busy_o, "R8 idle after timeout", {req_no, busy_o}, 2'b10);
    xfer(1'b1, 8'h5A, 0, 1'b1);
    xfer(1'b0, 8'hFF, 1, 1'b0);
    xfer(1'b0, 8'h00, 0, 1'b1);
    xfer(1'b1, 8'h01, 0, 1'b0);

    // R10: idle clock edges
    for (int k = 0; k < 10; k++) begin
      sclk_i = 1'b1; repeat (5) @(negedge clk_i);
      sclk_i = 1'b0; repeat (5) @(negedge clk_i);
      chk(!busy_o && req_no, "R10 idle edges ignored", {busy_o, req_no}, 2'b01);
    end
    xfer(1'b0, 8'h96, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule